// File: doc/BRIEF.md
# ModR/M Operand Address Decoder

This block turns the addressing byte of a 16-bit x86-style instruction into operand selects. It splits the byte into a two-bit mode, a three-bit register field and a three-bit r/m field. From these, the opcode's width and direction bits, the displacement bytes that follow, the current base, index and segment register values, and an optional segment override, it works out two things. The first is the register-file select of each operand. The second, when the r/m field names memory, is the 20-bit linear address of that operand.

The block also reports how many displacement bytes the instruction consumes, so the fetch logic can advance past them. It reports which operand is the destination and which is the source, after the direction-bit swap. The decode is combinational and is captured in one registered output stage when `dec_en` is high. The outputs hold their value while `dec_en` is low.

Top module: `modrm_addr_decoder`

## Requirements
- R1: `modrm` is split as mode = bits 7:6, reg = bits 5:3, r/m = bits 2:0. With `op_wide`=1 a register code c gives select `{c, 1'b0}`, where the index order is 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI and bit 0 is the high-byte flag.
- R2: With `op_wide`=0 a register code c gives select `{1'b0, c[1:0], c[2]}`. Codes 0-3 are the low bytes of AX, CX, DX and BX. Codes 4-7 are the high bytes of the same four registers.
- R3: Mode 0 with r/m 6 is a direct address. The offset is `{disp_hi, disp_lo}` with no base register, the default segment is DS, and `disp_len` is 2.
- R4: In mode 1, `disp_lo` is sign-extended to 16 bits and added to the base. `disp_len` is 1.
- R5: In mode 2, `{disp_hi, disp_lo}` is added to the base. `disp_len` is 2. Mode 0 (other than the direct case) adds nothing and gives `disp_len` 0.
- R6: The bases for r/m 0-7 are BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. Forms built on BP (r/m 2, 3, and 6 when not direct) default to SS. All other forms default to DS.
- R7: When `ovr_en`=1, `ovr_seg` replaces the default segment of a memory operand.
- R8: The offset wraps modulo 2^16 before use. The linear address is 16 x segment + offset, and it wraps modulo 2^20.
- R9: With `op_dir`=0 the r/m operand is the destination and the reg operand is the source. With `op_dir`=1 the two are swapped. The memory operand's flag (`dst_mem` or `src_mem`) is 1 and its select reads 0.
- R10: Mode 3 makes both operands registers. `dst_mem`, `src_mem`, `disp_len` and `lin_addr` are all 0, whatever `ovr_en` is.
- R11: Reset clears every output to 0. Outputs take the decode of the inputs present at a rising edge with `dec_en`=1. They are unchanged after an edge with `dec_en`=0. `out_valid` is 1 exactly in the cycle after a `dec_en` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_en | input | 1 | Capture the decode at this edge |
| op_wide | input | 1 | Opcode width bit (1 = 16-bit operands) |
| op_dir | input | 1 | Opcode direction bit (1 = reg field is destination) |
| modrm | input | 8 | Addressing byte |
| disp_lo | input | 8 | First byte after the addressing byte |
| disp_hi | input | 8 | Second byte after the addressing byte |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_ds | input | 16 | DS value |
| seg_ss | input | 16 | SS value |
| ovr_en | input | 1 | Segment override active |
| ovr_seg | input | 16 | Override segment value |
| out_valid | output | 1 | Outputs were captured at the last edge |
| dst_mem | output | 1 | Destination is the memory operand |
| src_mem | output | 1 | Source is the memory operand |
| dst_sel | output | 4 | Destination register select {index, high byte} |
| src_sel | output | 4 | Source register select {index, high byte} |
| disp_len | output | 2 | Displacement bytes consumed |
| lin_addr | output | 20 | Linear address of the memory operand |

## Verification
A vector table sweeps every mode against a fixed set of register values. The values are chosen so that each of the eight base forms, and each segment, lands on a distinct address. A wrong base pair, a missing sign extension or a wrong default segment therefore shows up as a different number. Byte-width codes 4-7 are paired with 0-3 so that high/low aliasing can be told apart from plain indexing. The direction bit is flipped on both register and memory forms to separate the swap from the select mapping. Directed cases push the offset past 16 bits and the segment sum past 20 bits to confirm each wrap. Further cases check the reset value, the one-edge capture and the hold with `dec_en` low.

// File: rtl/modrm_pkg.sv
package modrm_pkg;

  typedef enum logic [1:0] {
    MD_NODISP = 2'd0,
    MD_DISP8  = 2'd1,
    MD_DISP16 = 2'd2,
    MD_REG    = 2'd3
  } mode_e;

  // Register-file select: word index plus high-byte flag
  typedef struct packed {
    logic [2:0] idx;
    logic       hi;
  } reg_sel_t;

  localparam int unsigned SEL_W = $bits(reg_sel_t);

endpackage

// File: rtl/modrm_reg_map.sv
module modrm_reg_map
  import modrm_pkg::*;
(
  input  logic [2:0] code,
  input  logic       wide,
  output reg_sel_t   sel
);

  always_comb begin
    if (wide) begin
      sel.idx = code;
      sel.hi  = 1'b0;
    end else begin
      // byte codes 4..7 alias the upper half of words 0..3
      sel.idx = {1'b0, code[1:0]};
      sel.hi  = code[2];
    end
  end

endmodule

// File: rtl/modrm_ea_calc.sv
module modrm_ea_calc
  import modrm_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned ADDR_W   = WORD_W + SEG_SHIFT
) (
  input  mode_e             mode,
  input  logic [2:0]        rm,
  input  logic [7:0]        disp_lo,
  input  logic [7:0]        disp_hi,
  input  logic [WORD_W-1:0] reg_bx,
  input  logic [WORD_W-1:0] reg_bp,
  input  logic [WORD_W-1:0] reg_si,
  input  logic [WORD_W-1:0] reg_di,
  input  logic [WORD_W-1:0] seg_ds,
  input  logic [WORD_W-1:0] seg_ss,
  input  logic              ovr_en,
  input  logic [WORD_W-1:0] ovr_seg,
  output logic              is_mem,
  output logic [1:0]        disp_len,
  output logic [ADDR_W-1:0] lin_addr
);

  localparam int unsigned EXT_W = WORD_W - 8;

  logic              direct;
  logic              bp_based;
  logic [WORD_W-1:0] disp_word;
  logic [WORD_W-1:0] disp_val;
  logic [WORD_W-1:0] base_val;
  logic [WORD_W-1:0] offset;
  logic [WORD_W-1:0] seg_val;
  logic [ADDR_W-1:0] seg_scaled;
  logic [ADDR_W-1:0] off_ext;

  assign direct    = (mode == MD_NODISP) && (rm == 3'd6);
  assign is_mem    = (mode != MD_REG);
  assign disp_word = WORD_W'({disp_hi, disp_lo});

  always_comb begin
    unique case (mode)
      MD_DISP8:  disp_val = {{EXT_W{disp_lo[7]}}, disp_lo};
      MD_DISP16: disp_val = disp_word;
      default:   disp_val = direct ? disp_word : '0;
    endcase
  end

  always_comb begin
    unique case (rm)
      3'd0:    base_val = reg_bx + reg_si;
      3'd1:    base_val = reg_bx + reg_di;
      3'd2:    base_val = reg_bp + reg_si;
      3'd3:    base_val = reg_bp + reg_di;
      3'd4:    base_val = reg_si;
      3'd5:    base_val = reg_di;
      3'd6:    base_val = direct ? '0 : reg_bp;
      default: base_val = reg_bx;
    endcase
  end

  assign bp_based = (rm == 3'd2) || (rm == 3'd3) || ((rm == 3'd6) && !direct);

  always_comb begin
    if (ovr_en)        seg_val = ovr_seg;
    else if (bp_based) seg_val = seg_ss;
    else               seg_val = seg_ds;
  end

  // offset wraps at the word width before the segment is added
  assign offset     = base_val + disp_val;
  assign seg_scaled = {seg_val, {SEG_SHIFT{1'b0}}};
  assign off_ext    = {{SEG_SHIFT{1'b0}}, offset};

  always_comb begin
    if (is_mem) begin
      lin_addr = seg_scaled + off_ext;
      disp_len = direct ? 2'd2 : 2'(mode);
    end else begin
      lin_addr = '0;
      disp_len = 2'd0;
    end
  end

endmodule

// File: rtl/modrm_out_reg.sv
module modrm_out_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

endmodule

// File: rtl/modrm_addr_decoder.sv
module modrm_addr_decoder
  import modrm_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned ADDR_W   = WORD_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_en,
  input  logic              op_wide,
  input  logic              op_dir,
  input  logic [7:0]        modrm,
  input  logic [7:0]        disp_lo,
  input  logic [7:0]        disp_hi,
  input  logic [WORD_W-1:0] reg_bx,
  input  logic [WORD_W-1:0] reg_bp,
  input  logic [WORD_W-1:0] reg_si,
  input  logic [WORD_W-1:0] reg_di,
  input  logic [WORD_W-1:0] seg_ds,
  input  logic [WORD_W-1:0] seg_ss,
  input  logic              ovr_en,
  input  logic [WORD_W-1:0] ovr_seg,
  output logic              out_valid,
  output logic              dst_mem,
  output logic              src_mem,
  output logic [3:0]        dst_sel,
  output logic [3:0]        src_sel,
  output logic [1:0]        disp_len,
  output logic [ADDR_W-1:0] lin_addr
);

  localparam int unsigned BUNDLE_W = 2 + 2 * SEL_W + 2 + ADDR_W;

  mode_e             fld_mode;
  logic [2:0]        fld_reg;
  logic [2:0]        fld_rm;
  reg_sel_t          reg_side;
  reg_sel_t          rm_reg;
  reg_sel_t          rm_side;
  reg_sel_t          dst_c;
  reg_sel_t          src_c;
  logic              is_mem;
  logic              dst_mem_c;
  logic              src_mem_c;
  logic [1:0]        disp_len_c;
  logic [ADDR_W-1:0] lin_c;
  logic [BUNDLE_W-1:0] bundle_d;
  logic [BUNDLE_W-1:0] bundle_q;

  assign fld_mode = mode_e'(modrm[7:6]);
  assign fld_reg  = modrm[5:3];
  assign fld_rm   = modrm[2:0];

  modrm_reg_map u_map_reg (
    .code (fld_reg),
    .wide (op_wide),
    .sel  (reg_side)
  );

  modrm_reg_map u_map_rm (
    .code (fld_rm),
    .wide (op_wide),
    .sel  (rm_reg)
  );

  modrm_ea_calc #(
    .WORD_W    (WORD_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_ea (
    .mode     (fld_mode),
    .rm       (fld_rm),
    .disp_lo  (disp_lo),
    .disp_hi  (disp_hi),
    .reg_bx   (reg_bx),
    .reg_bp   (reg_bp),
    .reg_si   (reg_si),
    .reg_di   (reg_di),
    .seg_ds   (seg_ds),
    .seg_ss   (seg_ss),
    .ovr_en   (ovr_en),
    .ovr_seg  (ovr_seg),
    .is_mem   (is_mem),
    .disp_len (disp_len_c),
    .lin_addr (lin_c)
  );

  // memory operand carries a zero select; direction bit swaps the roles
  always_comb begin
    rm_side   = is_mem ? '0 : rm_reg;
    dst_c     = op_dir ? reg_side : rm_side;
    src_c     = op_dir ? rm_side  : reg_side;
    dst_mem_c = is_mem && !op_dir;
    src_mem_c = is_mem && op_dir;
  end

  assign bundle_d = {dst_mem_c, src_mem_c, dst_c, src_c, disp_len_c, lin_c};

  modrm_out_reg #(.WIDTH(BUNDLE_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (dec_en),
    .d     (bundle_d),
    .q     (bundle_q)
  );

  modrm_out_reg #(.WIDTH(1)) u_vld (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .d     (dec_en),
    .q     (out_valid)
  );

  assign {dst_mem, src_mem, dst_sel, src_sel, disp_len, lin_addr} = bundle_q;

endmodule

// File: rtl/modrm_dec_checker.sv
module modrm_dec_checker #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_en,
  input logic              op_dir,
  input logic [7:0]        modrm,
  input logic              out_valid,
  input logic              dst_mem,
  input logic              src_mem,
  input logic [3:0]        dst_sel,
  input logic [3:0]        src_sel,
  input logic [1:0]        disp_len,
  input logic [ADDR_W-1:0] lin_addr
);

  p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> out_valid);

  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dec_en) |-> ($stable(lin_addr) && $stable(dst_sel) && $stable(src_sel)
                        && $stable(disp_len)));

  p_reg_mode_no_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dec_en) && ($past(modrm[7:6]) == 2'd3))
      |-> (!dst_mem && !src_mem && (lin_addr == '0) && (disp_len == 2'd0)));

  p_dir_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dec_en) && ($past(modrm[7:6]) != 2'd3))
      |-> ((dst_mem == !$past(op_dir)) && (src_mem == $past(op_dir))));

  p_direct_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dec_en) && ($past(modrm) ==? 8'b00???110)) |-> (disp_len == 2'd2));

  p_disp8_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dec_en) && ($past(modrm[7:6]) == 2'd1)) |-> (disp_len == 2'd1));

endmodule

bind modrm_addr_decoder modrm_dec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_en    (dec_en),
  .op_dir    (op_dir),
  .modrm     (modrm),
  .out_valid (out_valid),
  .dst_mem   (dst_mem),
  .src_mem   (src_mem),
  .dst_sel   (dst_sel),
  .src_sel   (src_sel),
  .disp_len  (disp_len),
  .lin_addr  (lin_addr)
);

// File: tb/tb_modrm_addr_decoder.sv
module tb_modrm_addr_decoder;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        w;
    logic        d;
    logic [7:0]  m;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic        ovr;
    logic        edm;
    logic        esm;
    logic [3:0]  eds;
    logic [3:0]  ess;
    logic [1:0]  elen;
    logic [19:0] eaddr;
    logic [3:0]  req;
  } vec_t;

  // registers: BX=1000 BP=2000 SI=0030 DI=0400 DS=1234 SS=4000 override=0B80
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,8'hD3,8'h00,8'h00,1'b0,1'b0,1'b0,4'h6,4'h4,2'd0,20'h00000,4'd1},  // R1 BX <- DX
    '{1'b0,1'b0,8'hE7,8'h00,8'h00,1'b0,1'b0,1'b0,4'h7,4'h1,2'd0,20'h00000,4'd2},  // R2 BH <- AH
    '{1'b0,1'b1,8'hDD,8'h00,8'h00,1'b0,1'b0,1'b0,4'h6,4'h3,2'd0,20'h00000,4'd2},  // R2 BL <- CH
    '{1'b1,1'b0,8'h0E,8'h78,8'h56,1'b0,1'b1,1'b0,4'h0,4'h2,2'd2,20'h179B8,4'd3},  // R3 direct
    '{1'b1,1'b0,8'h47,8'hF0,8'h00,1'b0,1'b1,1'b0,4'h0,4'h0,2'd1,20'h13330,4'd4},  // R4 BX-16
    '{1'b1,1'b0,8'h44,8'h7F,8'hAA,1'b0,1'b1,1'b0,4'h0,4'h0,2'd1,20'h123EF,4'd4},  // R4 SI+127
    '{1'b1,1'b0,8'h81,8'h34,8'h12,1'b0,1'b1,1'b0,4'h0,4'h0,2'd2,20'h14974,4'd5},  // R5 BX+DI+1234
    '{1'b1,1'b0,8'h02,8'h55,8'h66,1'b0,1'b1,1'b0,4'h0,4'h0,2'd0,20'h42030,4'd6},  // R6 BP+SI SS
    '{1'b1,1'b0,8'h03,8'h00,8'h00,1'b0,1'b1,1'b0,4'h0,4'h0,2'd0,20'h42400,4'd6},  // R6 BP+DI SS
    '{1'b1,1'b0,8'h46,8'h05,8'h00,1'b0,1'b1,1'b0,4'h0,4'h0,2'd1,20'h42005,4'd6},  // R6 BP+5 SS
    '{1'b1,1'b0,8'h00,8'h00,8'h00,1'b0,1'b1,1'b0,4'h0,4'h0,2'd0,20'h13370,4'd6},  // R6 BX+SI DS
    '{1'b1,1'b0,8'h05,8'h00,8'h00,1'b0,1'b1,1'b0,4'h0,4'h0,2'd0,20'h12740,4'd6},  // R6 DI DS
    '{1'b1,1'b0,8'h03,8'h00,8'h00,1'b1,1'b1,1'b0,4'h0,4'h0,2'd0,20'h0DC00,4'd7},  // R7 override on BP form
    '{1'b1,1'b0,8'h06,8'h10,8'h00,1'b1,1'b1,1'b0,4'h0,4'h0,2'd2,20'h0B810,4'd7},  // R7 override direct
    '{1'b1,1'b0,8'h87,8'h23,8'hF1,1'b0,1'b1,1'b0,4'h0,4'h0,2'd2,20'h12463,4'd8},  // R8 16-bit offset wrap
    '{1'b1,1'b1,8'hB4,8'h10,8'h00,1'b0,1'b0,1'b1,4'hC,4'h0,2'd2,20'h12380,4'd9},  // R9 SI <- mem
    '{1'b0,1'b1,8'h65,8'h80,8'h00,1'b0,1'b0,1'b1,4'h1,4'h0,2'd1,20'h126C0,4'd9},  // R9 AH <- mem, DI-128
    '{1'b1,1'b0,8'hC0,8'h00,8'h00,1'b1,1'b0,1'b0,4'h0,4'h0,2'd0,20'h00000,4'd10}  // R10 override ignored
  };

  logic        clk;
  logic        rst_n;
  logic        dec_en;
  logic        op_wide;
  logic        op_dir;
  logic [7:0]  modrm;
  logic [7:0]  disp_lo;
  logic [7:0]  disp_hi;
  logic [15:0] reg_bx, reg_bp, reg_si, reg_di, seg_ds, seg_ss, ovr_seg;
  logic        ovr_en;
  logic        out_valid, dst_mem, src_mem;
  logic [3:0]  dst_sel, src_sel;
  logic [1:0]  disp_len;
  logic [19:0] lin_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  modrm_addr_decoder dut (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .op_wide(op_wide), .op_dir(op_dir),
    .modrm(modrm), .disp_lo(disp_lo), .disp_hi(disp_hi),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_ds(seg_ds), .seg_ss(seg_ss), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .out_valid(out_valid), .dst_mem(dst_mem), .src_mem(src_mem),
    .dst_sel(dst_sel), .src_sel(src_sel), .disp_len(disp_len), .lin_addr(lin_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic edm, input logic esm,
                           input logic [3:0] eds, input logic [3:0] ess,
                           input logic [1:0] elen, input logic [19:0] eaddr);
    check(tag, "dst_mem",  32'(dst_mem),  32'(edm));
    check(tag, "src_mem",  32'(src_mem),  32'(esm));
    check(tag, "dst_sel",  32'(dst_sel),  32'(eds));
    check(tag, "src_sel",  32'(src_sel),  32'(ess));
    check(tag, "disp_len", 32'(disp_len), 32'(elen));
    check(tag, "lin_addr", 32'(lin_addr), 32'(eaddr));
  endtask

  // drive at falling edge, capture at next rising edge, sample at following falling edge
  task automatic apply(input vec_t v);
    op_wide = v.w; op_dir = v.d; modrm = v.m;
    disp_lo = v.lo; disp_hi = v.hi; ovr_en = v.ovr; dec_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dec_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dec_en = 1'b0; op_wide = 1'b1; op_dir = 1'b0;
    modrm = 8'hFF; disp_lo = 8'hFF; disp_hi = 8'hFF; ovr_en = 1'b1;
    reg_bx = 16'h1000; reg_bp = 16'h2000; reg_si = 16'h0030; reg_di = 16'h0400;
    seg_ds = 16'h1234; seg_ss = 16'h4000; ovr_seg = 16'h0B80;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "out_valid at reset", 32'(out_valid), 32'd0);
    check_all("R11", 1'b0, 1'b0, 4'h0, 4'h0, 2'd0, 20'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "out_valid idle", 32'(out_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check_all($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].edm, VECS[i].esm,
                VECS[i].eds, VECS[i].ess, VECS[i].elen, VECS[i].eaddr);
    end

    // R11: valid for one cycle, then hold while dec_en is low
    apply(VECS[6]);
    check("R11", "out_valid after capture", 32'(out_valid), 32'd1);
    modrm = 8'h02; disp_lo = 8'h99; op_dir = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R11", "out_valid idle edge", 32'(out_valid), 32'd0);
    check_all("R11 hold", 1'b1, 1'b0, 4'h0, 4'h0, 2'd2, 20'h14974);

    // R8: 20-bit wrap of segment plus offset
    seg_ds = 16'hFFFF; reg_di = 16'h0020;
    apply('{1'b1,1'b0,8'h05,8'h00,8'h00,1'b0,1'b0,1'b0,4'h0,4'h0,2'd0,20'h0,4'd8});
    check("R8", "20-bit wrap", 32'(lin_addr), 32'h00010);

    // R3: direct ignores BP and uses DS even though r/m is 6
    seg_ds = 16'h1234; reg_bp = 16'hFFFF;
    apply('{1'b1,1'b0,8'h36,8'h01,8'h00,1'b0,1'b0,1'b0,4'h0,4'h0,2'd0,20'h0,4'd3});
    check("R3", "direct no base", 32'(lin_addr), 32'h12341);

    // R1: word reg field 7 (DI) against memory operand, direction 1
    apply('{1'b1,1'b1,8'h3F,8'h00,8'h00,1'b0,1'b0,1'b0,4'h0,4'h0,2'd0,20'h0,4'd1});
    check("R1", "dst_sel DI", 32'(dst_sel), 32'hE);
    check("R1", "bx form addr", 32'(lin_addr), 32'h13340);

    // R5: mode 0 other than direct uses no displacement bytes
    apply('{1'b1,1'b0,8'h04,8'hFF,8'hFF,1'b0,1'b0,1'b0,4'h0,4'h0,2'd0,20'h0,4'd5});
    check("R5", "mode0 disp_len", 32'(disp_len), 32'd0);
    check("R5", "mode0 addr", 32'(lin_addr), 32'h12370);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule